// File: doc/BRIEF.md
# LED Reaction Game Controller

This block sequences a reaction game on a small board. A game is a fixed run of nine rounds. Each round lights one of five target lamps, picked pseudo-randomly. The lamp stays lit for a window whose length the difficulty input sets. The player scores a point by pressing the button that sits behind the lit lamp while it is still lit. Between rounds there is a short dark gap. After the last round the controller flags the end of the game and shows the final score until a new start request arrives.

The pseudo-random pick comes from a small linear-feedback shift register. It advances on a one-cycle enable taken from a free-running divider, so nothing in the block runs on a derived clock. The window and gap lengths are computed from a clock-frequency parameter. A test configuration can therefore shrink every timing to a few dozen cycles. The buttons are assumed to be debounced already. The score leaves the block both as a binary digit and as a seven-segment pattern, and multiplexing of the display is left to the surrounding logic.

Top module: `reaction_game`

## Requirements
- R1: At most one lamp is lit at any time. Exactly one lamp is lit in every cycle of a round window, and no lamp is lit while no game is running.
- R2: The random source is a 4-bit shift register seeded with 1000 (binary) at reset. When it advances, it shifts toward the MSB and takes bit3 XOR bit2 into bit0. It advances once every TICK_DIV cycles on an enable from a free-running counter that starts at zero after reset. A round lights `led[i]`, where i is the register value modulo 5 in the cycle the round opens, and that lamp stays the same for the whole window.
- R3: A window lasts ON_UNIT*(level+1) cycles, where ON_UNIT = CLK_HZ/UNIT_DIV and `level` is sampled when the round opens.
- R4: A button counts as pressed on a 0-to-1 transition, and only the first press of a window is evaluated. If that press is exactly the lit button, the score rises by one; this includes a press in the last cycle of the window. The lamp goes dark in the next cycle.
- R5: A press of a wrong button, or of several buttons at once, ends the round at once with no point.
- R6: A round with no press in its window gives no point. Presses made after the window closes are ignored.
- R7: Consecutive rounds are separated by GAP_CYC = CLK_HZ/GAP_DIV dark cycles. `busy` is high from the cycle after the start request until the gap that follows the last round ends.
- R8: After ROUNDS rounds (9) and the closing gap, `done` rises and `busy` falls. The score then holds and presses are ignored. A start request then clears the score and opens round 1 in the next cycle.
- R9: A start request made while a game is running is ignored.
- R10: `seg` shows the score with segments a..g on bits 0..6, active high by default. The patterns are: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F (hex).
- R11: After reset no lamp is lit, the score is 0, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start or replay request, one cycle |
| btn | input | 5 | Debounced buttons, one per lamp |
| level | input | LVL_W | Difficulty, selects the window length |
| led | output | 5 | Target lamps |
| score | output | 4 | Score as a binary digit |
| seg | output | 7 | Score as a seven-segment pattern |
| busy | output | 1 | A game is in progress |
| done | output | 1 | Game over, final score held |

## Verification
Two functions can fall in the same cycle: the window running out and the evaluation of a press. The bench provokes this by pressing the lit button in the very last cycle of the window. It judges the outcome by requiring a point and a dark lamp one cycle later, so the press must win over the expiry. A second overlap is a start request that arrives in the middle of a round, on the same cycle the round logic is evaluating. The bench checks that the lamp and the score carry on unchanged. Every lamp choice is compared against an arithmetic model of the shift register that runs alongside the design.

// File: rtl/rg_pkg.sv
package rg_pkg;
   localparam int NUM_TGT = 5;
   localparam int RND_W   = 4;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ON   = 2'd1,
      ST_GAP  = 2'd2,
      ST_OVER = 2'd3
   } rg_state_e;
endpackage

// File: rtl/rg_rand.sv
module rg_rand #(
   parameter int TICK_DIV = 1000,
   parameter int W        = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] q
);
   logic tick;

   if (TICK_DIV < 1) begin : g_bad_div
      $error("rg_rand: TICK_DIV must be at least 1");
   end

   if (TICK_DIV == 1) begin : g_every
      assign tick = 1'b1;
   end else begin : g_div
      localparam int DW = $clog2(TICK_DIV);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         div_q <= '0;
         else if (div_q == DW'(TICK_DIV-1)) div_q <= '0;
         else                                div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == DW'(TICK_DIV-1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= {1'b1, {(W-1){1'b0}}};
      else if (tick) q <= {q[W-2:0], q[W-1] ^ q[W-2]};
   end
endmodule

// File: rtl/rg_timer.sv
module rg_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          zero
);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/rg_seg.sv
module rg_seg #(
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic [3:0] digit,
   output logic [6:0] seg
);
   logic [6:0] pat;

   always_comb begin
      case (digit)
         4'd0:    pat = 7'h3F;
         4'd1:    pat = 7'h06;
         4'd2:    pat = 7'h5B;
         4'd3:    pat = 7'h4F;
         4'd4:    pat = 7'h66;
         4'd5:    pat = 7'h6D;
         4'd6:    pat = 7'h7D;
         4'd7:    pat = 7'h07;
         4'd8:    pat = 7'h7F;
         4'd9:    pat = 7'h6F;
         default: pat = 7'h00;
      endcase
   end

   if (ACTIVE_LOW) begin : g_low
      assign seg = ~pat;
   end else begin : g_high
      assign seg = pat;
   end
endmodule

// File: rtl/reaction_game.sv
module reaction_game
   import rg_pkg::*;
#(
   parameter int CLK_HZ         = 50_000_000,
   parameter int UNIT_DIV       = 2,
   parameter int GAP_DIV        = 4,
   parameter int TICK_DIV       = 1000,
   parameter int ROUNDS         = 9,
   parameter int LVL_W          = 2,
   parameter bit SEG_ACTIVE_LOW = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [NUM_TGT-1:0] btn,
   input  logic [LVL_W-1:0]   level,
   output logic [NUM_TGT-1:0] led,
   output logic [3:0]         score,
   output logic [6:0]         seg,
   output logic               busy,
   output logic               done
);
   localparam int ON_UNIT = CLK_HZ / UNIT_DIV;
   localparam int GAP_CYC = CLK_HZ / GAP_DIV;
   localparam int ON_MAX  = ON_UNIT * (2 ** LVL_W);
   localparam int T_MAX   = (ON_MAX > GAP_CYC) ? ON_MAX : GAP_CYC;
   localparam int TW      = $clog2(T_MAX + 1);
   localparam int ROUND_W = $clog2(ROUNDS + 1);

   if (ROUNDS < 1 || ROUNDS > 9) begin : g_bad_rounds
      $error("reaction_game: ROUNDS must fit one decimal digit");
   end
   if (ON_UNIT < 1 || GAP_CYC < 1) begin : g_bad_time
      $error("reaction_game: window and gap must be at least one cycle");
   end

   rg_state_e          st, st_nxt;
   logic [RND_W-1:0]   rnd_q;
   logic [2:0]         sel;
   logic [ROUND_W-1:0] rounds;
   logic [NUM_TGT-1:0] btn_q, press;
   logic               tmr_zero, tmr_ld;
   logic [TW-1:0]      tmr_val, on_len;
   logic               pick, clr, inc_score, inc_round;

   rg_rand #(.TICK_DIV(TICK_DIV), .W(RND_W)) u_rand (
      .clk   (clk),
      .rst_n (rst_n),
      .q     (rnd_q)
   );

   rg_timer #(.TW(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_ld),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   rg_seg #(.ACTIVE_LOW(SEG_ACTIVE_LOW)) u_seg (
      .digit (score),
      .seg   (seg)
   );

   assign on_len = TW'(ON_UNIT) * (TW'(level) + TW'(1));
   assign press  = btn & ~btn_q;

   always_comb begin
      st_nxt    = st;
      tmr_ld    = 1'b0;
      tmr_val   = '0;
      pick      = 1'b0;
      clr       = 1'b0;
      inc_score = 1'b0;
      inc_round = 1'b0;
      case (st)
         ST_IDLE, ST_OVER: begin
            if (start) begin
               st_nxt  = ST_ON;
               clr     = 1'b1;
               pick    = 1'b1;
               tmr_ld  = 1'b1;
               tmr_val = on_len - TW'(1);
            end
         end
         ST_ON: begin
            if (press != '0 || tmr_zero) begin
               st_nxt    = ST_GAP;
               inc_round = 1'b1;
               inc_score = (press == led);
               tmr_ld    = 1'b1;
               tmr_val   = TW'(GAP_CYC - 1);
            end
         end
         default: begin
            if (tmr_zero) begin
               if (rounds == ROUND_W'(ROUNDS)) begin
                  st_nxt = ST_OVER;
               end else begin
                  st_nxt  = ST_ON;
                  pick    = 1'b1;
                  tmr_ld  = 1'b1;
                  tmr_val = on_len - TW'(1);
               end
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         btn_q  <= '0;
         sel    <= '0;
         score  <= '0;
         rounds <= '0;
      end else begin
         st    <= st_nxt;
         btn_q <= btn;
         if (pick) sel <= 3'(rnd_q % 4'd5);
         if (clr) begin
            score  <= '0;
            rounds <= '0;
         end else begin
            if (inc_score) score  <= score + 4'd1;
            if (inc_round) rounds <= rounds + 1'b1;
         end
      end
   end

   for (genvar i = 0; i < NUM_TGT; i++) begin : g_led
      assign led[i] = (st == ST_ON) && (sel == 3'(i));
   end

   assign busy = (st == ST_ON) || (st == ST_GAP);
   assign done = (st == ST_OVER);
endmodule

// File: rtl/rg_checker.sv
module rg_checker #(
   parameter int CLK_HZ   = 50_000_000,
   parameter int UNIT_DIV = 2,
   parameter int LVL_W    = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic [4:0] led,
   input logic [3:0] score,
   input logic       busy,
   input logic       done
);
   localparam int ON_MAX = (CLK_HZ / UNIT_DIV) * (2 ** LVL_W);
   localparam int CW     = $clog2(ON_MAX + 1);

   logic          past_ok;
   logic [CW-1:0] lit_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         past_ok <= 1'b0;
         lit_cnt <= '0;
      end else begin
         past_ok <= 1'b1;
         lit_cnt <= (led != '0) ? lit_cnt + 1'b1 : '0;
      end
   end

   p_single_led_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(led));

   p_dark_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (led == '0));

   p_led_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && led != '0 && $past(led) != '0) |-> (led == $past(led)));

   p_window_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (led != '0) |-> (lit_cnt < CW'(ON_MAX)));

   p_score_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && score != $past(score)) |-> (score == $past(score) + 4'd1 || score == 4'd0));

   p_final_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(score)));
endmodule

bind reaction_game rg_checker #(
   .CLK_HZ   (CLK_HZ),
   .UNIT_DIV (UNIT_DIV),
   .LVL_W    (LVL_W)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .led   (led),
   .score (score),
   .busy  (busy),
   .done  (done)
);

// File: tb/reaction_game_test.sv
module reaction_game_test;
   localparam int CLK_P    = 10;
   localparam int CLK_HZ   = 40;
   localparam int TICK_DIV = 3;
   localparam int ON_UNIT  = CLK_HZ / 2;
   localparam int GAP_CYC  = CLK_HZ / 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [4:0] btn = '0;
   logic [1:0] level = '0;
   logic [4:0] led;
   logic [3:0] score;
   logic [6:0] seg;
   logic       busy, done;

   int checks = 0;
   int errors = 0;
   int exp_score = 0;
   bit finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   reaction_game #(.CLK_HZ(CLK_HZ), .TICK_DIV(TICK_DIV)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .btn(btn), .level(level),
      .led(led), .score(score), .seg(seg), .busy(busy), .done(done));

   // model of the random source from R2
   logic [3:0] m_lfsr, m_prev;
   int         m_cnt;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_lfsr <= 4'b1000;
         m_prev <= 4'b1000;
         m_cnt  <= 0;
      end else begin
         m_prev <= m_lfsr;
         if (m_cnt == TICK_DIV-1) begin
            m_cnt  <= 0;
            m_lfsr <= {m_lfsr[2:0], m_lfsr[3] ^ m_lfsr[2]};
         end else begin
            m_cnt <= m_cnt + 1;
         end
      end
   end

   function automatic int seg_of(int d);
      case (d)
         0: return 'h3F; 1: return 'h06; 2: return 'h5B; 3: return 'h4F;
         4: return 'h66; 5: return 'h6D; 6: return 'h7D; 7: return 'h07;
         8: return 'h7F; 9: return 'h6F; default: return 0;
      endcase
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // wait for the next lit lamp, checking gap length (R7), choice (R2), one-hot (R1)
   task automatic wait_lit(input int pre, input bit chk_gap, output int idx);
      int dark = pre;
      for (int n = 0; n < 500 && led == '0; n++) begin
         dark++;
         step();
      end
      if (chk_gap) chk("R7 gap length", dark, GAP_CYC);
      chk("R1 one lamp lit", $countones(led), 1);
      idx = 0;
      for (int i = 0; i < 5; i++) if (led[i]) idx = i;
      chk("R2 lamp choice", idx, int'(m_prev) % 5);
   endtask

   task automatic start_game(input int lvl);
      level = 2'(lvl);
      start = 1'b1;
      step();
      start = 1'b0;
      exp_score = 0;
      chk("R8 start clears score", score, 0);
      chk("R7 busy after start", busy, 1);
   endtask

   task automatic hit_at(input int idx, input int k);
      for (int i = 0; i < k; i++) step();
      chk("R1 lamp still lit before press", led, 1 << idx);
      btn = 5'(1 << idx);
      step();
      exp_score++;
      chk("R4 lamp off after hit", led, 0);
      chk("R4 score after hit", score, exp_score);
      chk("R10 seg pattern", seg, seg_of(exp_score));
      btn = '0;
   endtask

   task automatic miss_press(input int idx, input bit twin);
      logic [4:0] b = 5'(1 << ((idx + 1) % 5));
      if (twin) b = b | 5'(1 << idx);
      btn = b;
      step();
      chk("R5 lamp off after wrong press", led, 0);
      chk("R5 no point for wrong press", score, exp_score);
      btn = '0;
   endtask

   task automatic timeout(input int lvl);
      int lit = 0;
      for (int n = 0; n < 500 && led != '0; n++) begin
         lit++;
         step();
      end
      chk("R3 window length", lit, ON_UNIT * (lvl + 1));
      chk("R6 no point on timeout", score, exp_score);
   endtask

   task automatic finish_game();
      int dark = 0;
      for (int n = 0; n < 500 && !done; n++) begin
         dark++;
         step();
      end
      chk("R7 closing gap length", dark, GAP_CYC);
      chk("R8 done raised", done, 1);
      chk("R8 busy dropped", busy, 0);
      chk("R8 final score", score, exp_score);
      for (int i = 0; i < 12; i++) begin
         btn = 5'(1 << (i % 5));
         step();
         btn = '0;
         step();
      end
      chk("R8 score held after game", score, exp_score);
      chk("R8 lamps dark after game", led, 0);
      chk("R8 still over", done, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      summary();
   end

   initial begin
      int idx;
      repeat (3) step();
      chk("R11 reset led", led, 0);
      chk("R11 reset score", score, 0);
      chk("R11 reset busy", busy, 0);
      chk("R11 reset done", done, 0);
      chk("R10 seg at zero", seg, seg_of(0));
      rst_n = 1'b1;
      repeat (7) step();
      chk("R1 dark while idle", led, 0);

      // game 1: mixed outcomes at level 0
      start_game(0);
      wait_lit(0, 1'b0, idx); hit_at(idx, 3);
      wait_lit(0, 1'b1, idx); hit_at(idx, ON_UNIT - 1);   // press in last cycle wins over expiry
      wait_lit(0, 1'b1, idx); miss_press(idx, 1'b0);
      wait_lit(0, 1'b1, idx); timeout(0);
      wait_lit(0, 1'b1, idx); miss_press(idx, 1'b1);
      wait_lit(0, 1'b1, idx); timeout(0);
      btn = 5'(1 << idx);                                 // late press in the gap
      step();
      btn = '0;
      chk("R6 late press ignored", score, exp_score);
      wait_lit(1, 1'b1, idx); hit_at(idx, 0);
      wait_lit(0, 1'b1, idx); timeout(0);
      wait_lit(0, 1'b1, idx); hit_at(idx, 10);
      finish_game();
      chk("R4 game 1 total", score, 4);

      // game 2: all hits at level 3, start pulse mid-game
      start_game(3);
      for (int r = 1; r <= 9; r++) begin
         wait_lit(0, r > 1, idx);
         if (r == 5) begin
            start = 1'b1;
            step();
            start = 1'b0;
            chk("R9 start ignored lamp", led, 5'(1 << idx));
            chk("R9 start ignored score", score, exp_score);
            hit_at(idx, 2);
         end else begin
            hit_at(idx, 5 * r);
         end
      end
      finish_game();

      // games 3 and 4: no presses, window length per level
      for (int g = 1; g <= 2; g++) begin
         start_game(g);
         for (int r = 1; r <= 9; r++) begin
            wait_lit(0, r > 1, idx);
            timeout(g);
         end
         finish_game();
         chk("R6 empty game scores zero", score, 0);
      end

      summary();
   end
endmodule